// File: doc/BRIEF.md
# Stored-Sequence Register Restore Engine

The engine rebuilds a device's register settings from a byte image held in a non-volatile memory. When a load command arrives, it reads the image one byte at a time, starting at memory address 0. Each byte is decoded as an instruction. Data instructions carry a block of register bytes together with a 16-bit start address and a trailing checksum. Condition instructions select which of the following blocks actually reach the register map. An end instruction finishes the run. Pause and unassigned codes pass through with no effect.

Memory reads use a simple request/acknowledge pair, so any memory timing is accepted. The register map receives one write strobe per byte, with an address and a data byte. Every block's checksum is recomputed, including blocks that the active condition keeps out of the register map. A single mismatch raises a fault flag that stays set until the next load. A run whose blocks all match ends with the complete flag set. After a run finishes, a guard interval must elapse before a new command is accepted.

Top module: `cfg_restore_exec`

## Requirements
- R1: A `load_req` pulse sampled while `busy` is low and the guard interval has expired starts a run. In the next cycle, `busy` is high, `done` and `fault` are low, and the active condition is null.
- R2: Image bytes are fetched one per `rom_req`/`rom_ack` handshake at addresses 0, 1, 2, … in order. Any acknowledge latency of one or more cycles is accepted.
- R3: An instruction byte 0x00–0x7F with value N is a data instruction. It is followed by the high byte of the target address, then the low byte (address bit 15 in bit 7 of the first byte), then N+1 data bytes, then one checksum byte.
- R4: The data bytes of a written block appear as one `reg_we` pulse each, at the target address, target+1, and so on, in image order. The address wraps from 0xFFFF to 0x0000.
- R5: The checksum is the sum modulo 256 of the block's data bytes. A mismatch with the stored byte sets `fault`, which stays set until the next accepted load.
- R6: On the end instruction 0xFF, `busy` falls and `done` rises exactly when no block of the run failed. `done` and `fault` are never high together.
- R7: Instructions 0xB0–0xBF set the active condition to their low nibble. A value of 0 means the null condition.
- R8: A data block is written only if the active condition is null or equals `cond_sel`, sampled when the block's low address byte arrives. A block that is not written is still read and checksum-checked, and it produces no `reg_we`.
- R9: Pause 0xA0 and the unassigned codes 0x80–0x9F, 0xA1–0xAF and 0xC0–0xFE are consumed with no write and no status change.
- R10: `load_req` is ignored while `busy` is high, and during the GUARD_CYCLES cycles after `busy` falls.
- R11: While `busy` is low, `done` and `fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Single-cycle load command |
| cond_sel | input | 4 | Condition number of this device |
| rom_req | output | 1 | Single-cycle read request |
| rom_addr | output | ROM_AW | Image byte address |
| rom_ack | input | 1 | Read data valid |
| rom_data | input | 8 | Image byte |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 16 | Register write address |
| reg_wdata | output | 8 | Register write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with all checksums matching |
| fault | output | 1 | At least one checksum mismatch in this run |

## Verification
The instruction phase and the byte counter shape everything the engine does. If either slips by one byte, address bytes are taken for data or a checksum byte is taken for an instruction. The write scoreboard then sees a wrong address or value at the very next strobe, and the run usually ends with a false `fault`. A wrong active condition, or `cond_sel` sampled at the wrong time, shows up as writes that are missing or extra within the block that follows. A broken guard timer or a broken busy gate shows up as a restarted run: the scoreboard sees duplicate writes, or `busy` rises when it should stay low a few cycles after a rejected command.

// File: rtl/cre_pkg.sv
package cre_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_DAT,
        ST_SUM
    } st_e;

    typedef enum logic [1:0] {
        OK_DATA,
        OK_COND,
        OK_END,
        OK_SKIP
    } opk_e;

    localparam logic [7:0] OPC_END      = 8'hFF;
    localparam logic [3:0] OPC_COND_HI  = 4'hB;
    localparam logic [3:0] COND_NULL    = 4'h0;

endpackage

// File: rtl/cre_opdec.sv
module cre_opdec
    import cre_pkg::*;
(
    input  logic [7:0] op,
    output opk_e       kind,
    output logic [6:0] len_m1,
    output logic [3:0] cond
);
    always_comb begin
        len_m1 = op[6:0];
        cond   = op[3:0];
        if (!op[7])                       kind = OK_DATA;
        else if (op == OPC_END)           kind = OK_END;
        else if (op[7:4] == OPC_COND_HI)  kind = OK_COND;
        else                              kind = OK_SKIP;
    end
endmodule

// File: rtl/cre_sum.sv
module cre_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] sum
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)      sum_d = '0;
        else if (add) sum_d = sum_q + din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sum == 8'h00);
endmodule

// File: rtl/cre_guard.sv
module cre_guard #(
    parameter int GUARD_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);
    localparam int GW = $clog2(GUARD_CYCLES + 1);
    localparam logic [GW-1:0] GLOAD = GW'(GUARD_CYCLES);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm)              cnt_d = GLOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    p_guard_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == GLOAD));
endmodule

// File: rtl/cfg_restore_exec.sv
module cfg_restore_exec
    import cre_pkg::*;
#(
    parameter int ROM_AW       = 12,
    parameter int GUARD_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [3:0]        cond_sel,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic              rom_ack,
    input  logic [7:0]        rom_data,
    output logic              reg_we,
    output logic [15:0]       reg_waddr,
    output logic [7:0]        reg_wdata,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    typedef struct packed {
        st_e              st;
        logic             pend;
        logic [ROM_AW-1:0] ptr;
        logic [6:0]       cnt;
        logic [15:0]      taddr;
        logic [3:0]       cond;
        logic             wen;
        logic             fault;
        logic             done;
        logic             we;
        logic [15:0]      waddr;
        logic [7:0]       wdata;
    } regs_t;

    regs_t r_d, r_q;

    opk_e       op_kind;
    logic [6:0] op_len;
    logic [3:0] op_cond;
    logic [7:0] sum_val;
    logic       g_ready;
    logic       take, start, sum_clr, sum_add, g_arm;

    cre_opdec u_dec (
        .op     (rom_data),
        .kind   (op_kind),
        .len_m1 (op_len),
        .cond   (op_cond)
    );

    cre_sum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .add   (sum_add),
        .din   (rom_data),
        .sum   (sum_val)
    );

    cre_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (g_arm),
        .ready (g_ready)
    );

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        take    = r_q.pend && rom_ack;
        start   = (r_q.st == ST_IDLE) && load_req && g_ready;
        rom_req = (r_q.st != ST_IDLE) && !r_q.pend;
        sum_clr = 1'b0;
        sum_add = 1'b0;
        g_arm   = 1'b0;

        if (rom_req) r_d.pend = 1'b1;

        if (start) begin
            r_d.st    = ST_OPC;
            r_d.pend  = 1'b0;
            r_d.ptr   = '0;
            r_d.cond  = COND_NULL;
            r_d.fault = 1'b0;
            r_d.done  = 1'b0;
        end else if (take) begin
            r_d.pend = 1'b0;
            r_d.ptr  = r_q.ptr + 1'b1;
            unique case (r_q.st)
                ST_OPC: begin
                    unique case (op_kind)
                        OK_DATA: begin
                            r_d.cnt = op_len;
                            r_d.st  = ST_AHI;
                            sum_clr = 1'b1;
                        end
                        OK_COND: r_d.cond = op_cond;
                        OK_END: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = !r_q.fault;
                            g_arm    = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_AHI: begin
                    r_d.taddr[15:8] = rom_data;
                    r_d.st          = ST_ALO;
                end
                ST_ALO: begin
                    r_d.taddr[7:0] = rom_data;
                    r_d.wen        = (r_q.cond == COND_NULL) || (r_q.cond == cond_sel);
                    r_d.st         = ST_DAT;
                end
                ST_DAT: begin
                    sum_add     = 1'b1;
                    r_d.we      = r_q.wen;
                    r_d.waddr   = r_q.taddr;
                    r_d.wdata   = rom_data;
                    r_d.taddr   = r_q.taddr + 16'd1;
                    r_d.cnt     = r_q.cnt - 7'd1;
                    if (r_q.cnt == '0) r_d.st = ST_SUM;
                end
                ST_SUM: begin
                    if (rom_data != sum_val) r_d.fault = 1'b1;
                    r_d.st = ST_OPC;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rom_addr  = r_q.ptr;
    assign reg_we    = r_q.we;
    assign reg_waddr = r_q.waddr;
    assign reg_wdata = r_q.wdata;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign fault     = r_q.fault;

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !busy && g_ready) |=> (busy && !done && !fault));

    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rom_req && rom_addr == '0));

    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |=> !rom_req);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && busy) |=> fault);

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_write_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> busy);

    p_guard_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !g_ready && load_req) |=> !busy);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_req) |=> ($stable(done) && $stable(fault)));
endmodule

// File: tb/cfg_restore_exec_bench.sv
module cfg_restore_exec_bench;
    localparam int AW    = 12;
    localparam int GUARD = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_req = 1'b0;
    logic [3:0]    cond_sel = 4'd0;
    logic          rom_req;
    logic [AW-1:0] rom_addr;
    logic          rom_ack = 1'b0;
    logic [7:0]    rom_data = 8'h00;
    logic          reg_we;
    logic [15:0]   reg_waddr;
    logic [7:0]    reg_wdata;
    logic          busy, done, fault;

    always #2.5 clk = ~clk;

    cfg_restore_exec #(.ROM_AW(AW), .GUARD_CYCLES(GUARD)) u_cfg_restore_exec (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .cond_sel(cond_sel),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack),
        .rom_data(rom_data), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .busy(busy), .done(done), .fault(fault)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:(1<<AW)-1];
    logic [23:0] expq [$];
    int wp = 0;
    int rom_lat = 1;
    int lat_cnt = 0;
    logic [AW-1:0] cap;

    // memory model with programmable latency
    always @(posedge clk) begin
        rom_ack <= 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                rom_ack  <= 1'b1;
                rom_data <= mem[cap];
            end
        end else if (rom_req) begin
            cap     <= rom_addr;
            lat_cnt <= rom_lat;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every register write (R4, R8)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected write", {reg_waddr, reg_wdata}, 0);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                chk({reg_waddr, reg_wdata} == e, "R4 write addr/data",
                    {reg_waddr, reg_wdata}, e);
            end
        end
    end

    task automatic clear_img();
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
        wp = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    // data block: R3 layout, opcode N, addr hi, addr lo, N+1 bytes, checksum
    task automatic emit_blk(input int n, input logic [15:0] a, input int seed, input bit bad);
        logic [7:0] s;
        s = 8'h00;
        emit(8'(n));
        emit(a[15:8]);
        emit(a[7:0]);
        for (int i = 0; i <= n; i++) begin
            logic [7:0] v;
            v = 8'(seed + i * 37);
            emit(v);
            s = s + v;
        end
        emit(bad ? (s ^ 8'h5A) : s);
    endtask

    // independent model of the instruction stream (R3-R9)
    task automatic build_expect(input logic [3:0] sel, output bit exp_fault);
        int p;
        logic [3:0] c;
        p = 0;
        c = 4'd0;
        exp_fault = 1'b0;
        while (p < (1<<AW)) begin
            logic [7:0] op;
            op = mem[p];
            p++;
            if (op == 8'hFF) break;
            if (op < 8'h80) begin
                logic [15:0] a;
                logic [7:0] s;
                bit en;
                a = {mem[p], mem[p+1]};
                p += 2;
                s = 8'h00;
                en = (c == 4'd0) || (c == sel);
                for (int i = 0; i <= int'(op); i++) begin
                    if (en) expq.push_back({a, mem[p]});
                    s = s + mem[p];
                    a = a + 16'd1;
                    p++;
                end
                if (mem[p] != s) exp_fault = 1'b1;
                p++;
            end else if (op[7:4] == 4'hB) begin
                c = op[3:0];
            end
        end
    endtask

    task automatic pulse_load();
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
    endtask

    task automatic run(input logic [3:0] sel, input int lat, input bit poke, input string tag);
        bit ef;
        int n;
        cond_sel = sel;
        rom_lat  = lat;
        build_expect(sel, ef);
        repeat (GUARD + 4) @(negedge clk);
        pulse_load();
        chk(busy && !done && !fault, "R1 start state", {busy, done, fault}, 3'b100);
        if (poke) begin
            repeat (20) @(negedge clk);
            pulse_load();
        end
        n = 0;
        while (busy && n < 40000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(!busy, {"R6 busy falls ", tag}, busy, 0);
        chk(expq.size() == 0, {"R4 all writes seen ", tag}, expq.size(), 0);
        chk(fault == ef, {"R5 fault ", tag}, fault, ef);
        chk(done == !ef, {"R6 done ", tag}, done, !ef);
        expq.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !fault && !rom_req && !reg_we, "R1 reset state",
            {busy, done, fault, rom_req, reg_we}, 0);
        rst_n = 1'b1;

        // plain block
        clear_img();
        emit_blk(3, 16'h1234, 5, 1'b0);
        emit(8'hFF);
        run(4'd0, 1, 1'b0, "R3 single block");

        // skip codes and conditions (R7, R8, R9)
        clear_img();
        emit(8'hA0); emit(8'h85); emit(8'hC3); emit(8'hA7);
        emit_blk(0, 16'h0010, 9, 1'b0);
        emit(8'hB5); emit_blk(2, 16'h2000, 11, 1'b0);
        emit(8'hB3); emit_blk(1, 16'h3000, 13, 1'b0);
        emit(8'hB0); emit_blk(0, 16'h4000, 17, 1'b0);
        emit(8'hA0);
        emit(8'hFF);
        run(4'd5, 1, 1'b0, "R7 R8 R9 sel5");
        run(4'd3, 3, 1'b0, "R8 sel3 slow R2");
        run(4'd7, 2, 1'b0, "R8 sel7");

        // R11 and R10: command right after completion is ignored
        pulse_load();
        repeat (3) @(negedge clk);
        chk(!busy, "R10 guard ignores load", busy, 0);
        chk(done && !fault, "R11 status held", {done, fault}, 2'b10);

        // bad checksum in skipped block, later good block (R5 sticky, R8)
        clear_img();
        emit(8'hB9); emit_blk(2, 16'h5000, 21, 1'b1);
        emit(8'hB0); emit_blk(1, 16'h6000, 23, 1'b0);
        emit(8'hFF);
        run(4'd5, 1, 1'b0, "R5 skipped bad");
        chk(!done, "R6 no done with fault", done, 0);

        // bad checksum in a written block
        clear_img();
        emit_blk(4, 16'h7000, 29, 1'b1);
        emit(8'hFF);
        run(4'd0, 2, 1'b0, "R5 written bad");

        // long block with address wrap and mid-run command (R4, R10)
        clear_img();
        emit_blk(127, 16'hFFC0, 31, 1'b0);
        emit(8'hFF);
        run(4'd0, 1, 1'b1, "R4 wrap R10 busy");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule